// File: doc/BRIEF.md
# Burst-Consolidating Multichannel Write Multiplexer

This block lets several compressed-data channels share one 64-bit memory write port. Each channel sits behind a show-ahead FIFO that reports its fill level, and it owns a circular buffer in system memory, described by a word base and a word size. The multiplexer picks channels in turn. It waits until a channel holds a full 16-beat burst, or until that channel flags that its FIFO holds the end of a frame. It then issues one address phase followed by the matching data beats.

For every channel the block keeps two sets of status pointers. The issued set moves when a burst's last beat leaves the block. The confirmed set moves when the write response for that burst comes back. Each set holds the offset of the next word to be written and the offset at which the most recent frame ends, which is where the next frame starts. Responses are taken to return in issue order. Any response code other than OKAY latches a sticky error flag.

Top module: `wr_burst_mux`

## Requirements
- R1: After reset the address and data valids are low, every status pointer is zero and the error flag is low.
- R2: A channel with fewer than 16 words in its FIFO and `ch_flush` low is not served: no address phase is issued for it and its FIFO is not popped.
- R3: A channel with at least 16 words and at least 16 words of room before its buffer end gets a 16-beat burst: `aw_len` is 15 and `w_last` is high on the 16th beat.
- R4: A channel with `ch_flush` high and a nonzero level is served with a burst of length min(level, 16, room to buffer end).
- R5: `aw_addr` is the byte address (base + offset) * 8. A burst never passes the end of its buffer, and the offset wraps from size back to 0.
- R6: `aw_tag` carries the channel number. Data beats are the channel's FIFO words in FIFO order, with exactly one `ch_pop` pulse for each accepted beat and none for other channels.
- R7: Channels are granted round-robin. After a burst for channel c, the search for the next grant starts at channel c+1, modulo the channel count.
- R8: When a burst's last beat is accepted, the issued write pointer becomes the offset after that beat. If any beat of the burst carried `ch_last`, the issued frame-start pointer becomes the offset after the last such beat.
- R9: Each write-response handshake copies, in order, the end offset and any frame-start offset of the oldest outstanding burst into that channel's confirmed pointers.
- R10: No more than 4 bursts are outstanding without a response. While 4 are outstanding, no new address phase starts.
- R11: A response with `b_resp` not equal to 2'b00 sets `st_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_base | input | NCH*PW | Per-channel buffer base, in 64-bit words |
| cfg_size | input | NCH*PW | Per-channel buffer size, in 64-bit words (nonzero) |
| ch_level | input | NCH*LVW | Per-channel FIFO fill level |
| ch_flush | input | NCH | Channel FIFO holds a frame end; serve short bursts |
| ch_last | input | NCH | Head word of the channel FIFO is the last word of a frame |
| ch_data | input | NCH*DW | Head word of each channel FIFO |
| ch_pop | output | NCH | Pops the head word of a channel FIFO |
| aw_valid | output | 1 | Address phase valid |
| aw_ready | input | 1 | Address phase accepted |
| aw_addr | output | PW+3 | Burst start byte address |
| aw_len | output | 4 | Beats minus one |
| aw_tag | output | CHW | Channel number of the burst |
| w_valid | output | 1 | Data beat valid |
| w_ready | input | 1 | Data beat accepted |
| w_data | output | DW | Data beat |
| w_last | output | 1 | Final beat of the burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response accepted |
| b_resp | input | 2 | Response code, 2'b00 is OKAY |
| st_wr_issued | output | NCH*PW | Next write offset, as issued |
| st_wr_done | output | NCH*PW | Next write offset, as confirmed |
| st_fs_issued | output | NCH*PW | Frame-start offset, as issued |
| st_fs_done | output | NCH*PW | Frame-start offset, as confirmed |
| st_err | output | 1 | Sticky non-OKAY response flag |

## Verification
The hardest state to reach from the ports has the issued and confirmed pointers apart while the outstanding limit holds back a waiting burst. The bench reaches it by having its memory model withhold every write response while four channels, plus a second burst on one of them, become eligible at once. It then checks that exactly four bursts went out, that the issued offsets have advanced past the confirmed ones, and that the fifth burst follows only after the responses are released. A buffer shorter than two bursts is flushed mid-way, which forces a split at the wrap point.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_ADDR = 2'd1,
    WB_DATA = 2'd2
  } wb_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/wbm_rst_sync.sv
module wbm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/wbm_rr_arb.sv
module wbm_rr_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           adv,
  input  logic [CHW-1:0] adv_idx,
  output logic           gnt_vld,
  output logic [CHW-1:0] gnt_idx
);
  logic [CHW-1:0] ptr_q, ptr_d;

  // search starts at the rotating pointer and wraps once around
  always_comb begin
    int c;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < NCH; k++) begin
      c = (int'(ptr_q) + k) % NCH;
      if (!gnt_vld && req[c]) begin
        gnt_vld = 1'b1;
        gnt_idx = CHW'(c);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (adv_idx == CHW'(NCH - 1)) ? '0 : adv_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_GNT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_idx]); // R7
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NCH); // R7
endmodule

// File: rtl/wbm_resp_track.sv
module wbm_resp_track import wbm_pkg::*; #(
  parameter int NCH  = 4,
  parameter int PW   = 20,
  parameter int OUTS = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW  = (OUTS > 1) ? $clog2(OUTS) : 1,
  localparam int CW  = $clog2(OUTS + 1),
  localparam int EW  = CHW + 2 * PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [CHW-1:0]  push_ch,
  input  logic [PW-1:0]   push_end,
  input  logic            push_fsv,
  input  logic [PW-1:0]   push_fso,
  input  logic            b_valid,
  input  logic [1:0]      b_resp,
  output logic            b_ready,
  output logic            full,
  output logic [NCH*PW-1:0] done_wr,
  output logic [NCH*PW-1:0] done_fs,
  output logic            err
);
  logic [EW-1:0]  q_mem [OUTS];
  logic [QW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           err_q, err_d;
  logic [PW-1:0]  dwr_q [NCH];
  logic [PW-1:0]  dwr_d [NCH];
  logic [PW-1:0]  dfs_q [NCH];
  logic [PW-1:0]  dfs_d [NCH];
  logic [CHW-1:0] h_ch;
  logic [PW-1:0]  h_end, h_fso;
  logic           h_fsv, pop;

  function automatic logic [QW-1:0] q_next(input logic [QW-1:0] p);
    return (p == QW'(OUTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign {h_ch, h_end, h_fsv, h_fso} = q_mem[rp_q];
  assign b_ready = (cnt_q != '0);
  assign full    = (cnt_q == CW'(OUTS));
  assign pop     = b_valid && b_ready;
  assign err     = err_q;

  always_comb begin
    wp_d  = push ? q_next(wp_q) : wp_q;
    rp_d  = pop  ? q_next(rp_q) : rp_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    err_d = err_q || (pop && (b_resp != RESP_OKAY));
    for (int c = 0; c < NCH; c++) begin
      dwr_d[c] = dwr_q[c];
      dfs_d[c] = dfs_q[c];
      if (pop && (h_ch == CHW'(c))) begin
        dwr_d[c] = h_end;
        if (h_fsv) dfs_d[c] = h_fso;
      end
    end
  end

  // entry storage carries no reset: only slots below the count are read
  always_ff @(posedge clk) begin
    if (push) q_mem[wp_q] <= {push_ch, push_end, push_fsv, push_fso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        dwr_q[c] <= '0;
        dfs_q[c] <= '0;
      end
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
      for (int c = 0; c < NCH; c++) begin
        dwr_q[c] <= dwr_d[c];
        dfs_q[c] <= dfs_d[c];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign done_wr[i*PW +: PW] = dwr_q[i];
    assign done_fs[i*PW +: PW] = dfs_q[i];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= OUTS); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R11
endmodule

// File: rtl/wr_burst_mux.sv
module wr_burst_mux import wbm_pkg::*; #(
  parameter int NCH  = 4,
  parameter int DW   = 64,
  parameter int PW   = 20,
  parameter int LVW  = 6,
  parameter int MAXB = 16,
  parameter int OUTS = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LW  = $clog2(MAXB),
  localparam int BLW = LW + 1,
  localparam int AW  = PW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*PW-1:0] cfg_base,
  input  logic [NCH*PW-1:0] cfg_size,
  input  logic [NCH*LVW-1:0] ch_level,
  input  logic [NCH-1:0]    ch_flush,
  input  logic [NCH-1:0]    ch_last,
  input  logic [NCH*DW-1:0] ch_data,
  output logic [NCH-1:0]    ch_pop,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [AW-1:0]     aw_addr,
  output logic [LW-1:0]     aw_len,
  output logic [CHW-1:0]    aw_tag,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DW-1:0]     w_data,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [1:0]        b_resp,
  output logic [NCH*PW-1:0] st_wr_issued,
  output logic [NCH*PW-1:0] st_wr_done,
  output logic [NCH*PW-1:0] st_fs_issued,
  output logic [NCH*PW-1:0] st_fs_done,
  output logic              st_err
);
  logic srst_n;

  wbm_rst_sync i_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  logic [PW-1:0]  base_a [NCH];
  logic [PW-1:0]  size_a [NCH];
  logic [BLW-1:0] cap [NCH];
  logic [NCH-1:0] elig, arb_req;
  logic [PW-1:0]  wr_off_q [NCH];
  logic [PW-1:0]  wr_off_d [NCH];
  logic [PW-1:0]  fs_iss_q [NCH];
  logic [PW-1:0]  fs_iss_d [NCH];

  wb_state_e      state_q, state_d;
  logic [CHW-1:0] gidx_q, gidx_d;
  logic [BLW-1:0] blen_q, blen_d, beat_q, beat_d;
  logic [PW-1:0]  start_q, start_d, cur_q, cur_d, fso_q, fso_d;
  logic           fsv_q, fsv_d;

  logic           gnt_vld, trk_full, beat_ok, burst_end, sel_last, fs_now;
  logic [CHW-1:0] gnt_idx;
  logic [PW-1:0]  size_sel, base_sel, cur_nx, fs_val;
  logic [PW:0]    cur_inc;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign base_a[i] = cfg_base[i*PW +: PW];
    assign size_a[i] = cfg_size[i*PW +: PW];
    assign ch_pop[i] = beat_ok && (gidx_q == CHW'(i));
    assign st_wr_issued[i*PW +: PW] = wr_off_q[i];
    assign st_fs_issued[i*PW +: PW] = fs_iss_q[i];

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!srst_n)
      ch_pop[i] |-> (ch_level[i*LVW +: LVW] != '0)); // R6
  end

  // eligibility and burst length per channel: full burst, or flush of a short tail,
  // always clipped at the buffer end
  always_comb begin
    logic [PW:0] lvl_x, room_x, cw;
    for (int c = 0; c < NCH; c++) begin
      lvl_x  = (PW+1)'(ch_level[c*LVW +: LVW]);
      room_x = {1'b0, size_a[c]} - {1'b0, wr_off_q[c]};
      cw     = (PW+1)'(MAXB);
      if (lvl_x < cw)  cw = lvl_x;
      if (room_x < cw) cw = room_x;
      cap[c]  = BLW'(cw);
      elig[c] = ((lvl_x >= (PW+1)'(MAXB)) || (ch_flush[c] && (lvl_x != '0)))
                && (room_x != '0);
    end
  end

  assign arb_req = elig & {NCH{(state_q == WB_IDLE) && !trk_full}};

  wbm_rr_arb #(.NCH(NCH)) i_arb (
    .clk(clk), .rst_n(srst_n), .req(arb_req),
    .adv(burst_end), .adv_idx(gidx_q),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  assign size_sel  = size_a[gidx_q];
  assign base_sel  = base_a[gidx_q];
  assign sel_last  = ch_last[gidx_q];
  assign cur_inc   = {1'b0, cur_q} + 1'b1;
  assign cur_nx    = (cur_inc == {1'b0, size_sel}) ? '0 : cur_inc[PW-1:0];
  assign beat_ok   = (state_q == WB_DATA) && w_ready;
  assign burst_end = beat_ok && (beat_q == blen_q - BLW'(1));
  assign fs_now    = fsv_q || sel_last;
  assign fs_val    = sel_last ? cur_nx : fso_q;

  assign aw_valid = (state_q == WB_ADDR);
  assign aw_addr  = {base_sel + start_q, 3'b000};
  assign aw_len   = LW'(blen_q - BLW'(1));
  assign aw_tag   = gidx_q;
  assign w_valid  = (state_q == WB_DATA);
  assign w_last   = w_valid && (beat_q == blen_q - BLW'(1));
  assign w_data   = ch_data[gidx_q*DW +: DW];

  always_comb begin
    state_d = state_q;
    gidx_d  = gidx_q;
    blen_d  = blen_q;
    beat_d  = beat_q;
    start_d = start_q;
    cur_d   = cur_q;
    fsv_d   = fsv_q;
    fso_d   = fso_q;
    case (state_q)
      WB_IDLE: if (gnt_vld) begin
        state_d = WB_ADDR;
        gidx_d  = gnt_idx;
        blen_d  = cap[gnt_idx];
        start_d = wr_off_q[gnt_idx];
        cur_d   = wr_off_q[gnt_idx];
        beat_d  = '0;
        fsv_d   = 1'b0;
      end
      WB_ADDR: if (aw_ready) state_d = WB_DATA;
      WB_DATA: if (w_ready) begin
        beat_d = beat_q + 1'b1;
        cur_d  = cur_nx;
        if (sel_last) begin
          fsv_d = 1'b1;
          fso_d = cur_nx;
        end
        if (burst_end) state_d = WB_IDLE;
      end
      default: state_d = WB_IDLE;
    endcase
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      wr_off_d[c] = wr_off_q[c];
      fs_iss_d[c] = fs_iss_q[c];
      if (burst_end && (gidx_q == CHW'(c))) begin
        wr_off_d[c] = cur_nx;
        if (fs_now) fs_iss_d[c] = fs_val;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= WB_IDLE;
      gidx_q  <= '0;
      blen_q  <= '0;
      beat_q  <= '0;
      start_q <= '0;
      cur_q   <= '0;
      fsv_q   <= 1'b0;
      fso_q   <= '0;
      for (int c = 0; c < NCH; c++) begin
        wr_off_q[c] <= '0;
        fs_iss_q[c] <= '0;
      end
    end else begin
      state_q <= state_d;
      gidx_q  <= gidx_d;
      blen_q  <= blen_d;
      beat_q  <= beat_d;
      start_q <= start_d;
      cur_q   <= cur_d;
      fsv_q   <= fsv_d;
      fso_q   <= fso_d;
      for (int c = 0; c < NCH; c++) begin
        wr_off_q[c] <= wr_off_d[c];
        fs_iss_q[c] <= fs_iss_d[c];
      end
    end
  end

  wbm_resp_track #(.NCH(NCH), .PW(PW), .OUTS(OUTS)) i_track (
    .clk(clk), .rst_n(srst_n),
    .push(burst_end), .push_ch(gidx_q), .push_end(cur_nx),
    .push_fsv(fs_now), .push_fso(fs_val),
    .b_valid(b_valid), .b_resp(b_resp), .b_ready(b_ready),
    .full(trk_full), .done_wr(st_wr_done), .done_fs(st_fs_done), .err(st_err)
  );

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len)); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
    aw_valid |-> (blen_q != '0) && (int'(blen_q) <= MAXB)); // R4
  AST_IN_BUFFER: assert property (@(posedge clk) disable iff (!srst_n)
    aw_valid |-> ({1'b0, start_q} + (PW+1)'(blen_q)) <= {1'b0, size_sel}); // R5
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(ch_pop)); // R6
  AST_AW_OUT_LIMIT: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(aw_valid) |-> $past(!trk_full)); // R10
endmodule

// File: tb/test_wr_burst_mux.sv
`timescale 1ns/1ps
module test_wr_burst_mux;
  localparam int NCH = 4;
  localparam int DW  = 64;
  localparam int PW  = 20;
  localparam int LVW = 6;
  localparam int AW  = PW + 3;

  logic clk, rst_n;
  logic [NCH*PW-1:0]  cfg_base, cfg_size;
  logic [NCH*LVW-1:0] ch_level;
  logic [NCH-1:0]     ch_flush, ch_last, ch_pop;
  logic [NCH*DW-1:0]  ch_data;
  logic               aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready, st_err;
  logic [AW-1:0]      aw_addr;
  logic [3:0]         aw_len;
  logic [1:0]         aw_tag, b_resp;
  logic [DW-1:0]      w_data;
  logic [NCH*PW-1:0]  st_wr_issued, st_wr_done, st_fs_issued, st_fs_done;

  wr_burst_mux i_wr_burst_mux (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .ch_level(ch_level), .ch_flush(ch_flush), .ch_last(ch_last), .ch_data(ch_data),
    .ch_pop(ch_pop), .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_tag(aw_tag), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready),
    .b_resp(b_resp), .st_wr_issued(st_wr_issued), .st_wr_done(st_wr_done),
    .st_fs_issued(st_fs_issued), .st_fs_done(st_fs_done), .st_err(st_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // channel FIFO models
  logic [DW-1:0] fdat  [NCH][64];
  logic          flast [NCH][64];
  logic [5:0]    fwp [NCH];
  logic [5:0]    frp [NCH];
  int            pseq [NCH];
  int            bbase [NCH];
  int            bsize [NCH];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_level[c*LVW +: LVW] = fwp[c] - frp[c];
      ch_data[c*DW +: DW]    = fdat[c][frp[c]];
      ch_last[c]             = flast[c][frp[c]];
    end
  end

  int total, bad, mon_total, mon_bad;
  int nburst, outs, outs_max;
  int log_tag [256];
  int log_len [256];
  bit b_hold, stall, finished;
  logic [1:0] resp_code;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int fld(input logic [NCH*PW-1:0] v, input int c);
    return int'(v[c*PW +: PW]);
  endfunction

  // memory slave and monitor: samples at negedge, drives just after posedge
  initial begin
    int exp_off [NCH];
    int exp_seq [NCH];
    int cur_tag, tog;
    bit aw_hs, w_hs, b_hs;
    for (int c = 0; c < NCH; c++) begin
      frp[c] = '0; exp_off[c] = 0; exp_seq[c] = 0;
    end
    aw_ready = 1'b1; w_ready = 1'b1; b_valid = 1'b0; b_resp = 2'b00;
    nburst = 0; outs = 0; outs_max = 0; cur_tag = 0; tog = 0;
    mon_total = 0; mon_bad = 0;
    forever begin
      @(negedge clk);
      aw_hs = aw_valid && aw_ready;
      w_hs  = w_valid && w_ready;
      b_hs  = b_valid && b_ready;
      if (aw_hs) begin
        cur_tag = int'(aw_tag);
        mon_total++;
        if (aw_addr != AW'((bbase[cur_tag] + exp_off[cur_tag]) * 8) ||
            int'(aw_len) + 1 > bsize[cur_tag] - exp_off[cur_tag]) begin
          mon_bad++;
          $display("FAIL R5 burst address/room ch%0d: actual=%0d expected=%0d",
                   cur_tag, aw_addr, (bbase[cur_tag] + exp_off[cur_tag]) * 8);
        end
        exp_off[cur_tag] = exp_off[cur_tag] + int'(aw_len) + 1;
        if (exp_off[cur_tag] == bsize[cur_tag]) exp_off[cur_tag] = 0;
        if (nburst < 256) begin
          log_tag[nburst] = cur_tag;
          log_len[nburst] = int'(aw_len) + 1;
        end
        nburst++;
      end
      if (w_hs) begin
        mon_total++;
        if (w_data != {8'(cur_tag), 56'(exp_seq[cur_tag])} || !ch_pop[cur_tag] ||
            $countones(ch_pop) != 1) begin
          mon_bad++;
          $display("FAIL R6 data beat ch%0d: actual=%0h expected=%0h",
                   cur_tag, w_data, {8'(cur_tag), 56'(exp_seq[cur_tag])});
        end
        exp_seq[cur_tag]++;
        if (w_last) begin
          outs++;
          if (outs > outs_max) outs_max = outs;
        end
      end
      if (b_hs) outs--;
      @(posedge clk);
      #1;
      if (w_hs) frp[cur_tag] = frp[cur_tag] + 1'b1;
      tog++;
      aw_ready = stall ? tog[0] : 1'b1;
      w_ready  = stall ? tog[1] : 1'b1;
      b_valid  = (outs > 0) && !b_hold;
      b_resp   = resp_code;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push(input int c, input int n, input bit last_at_end);
    for (int k = 0; k < n; k++) begin
      fdat[c][fwp[c]]  = {8'(c), 56'(pseq[c])};
      flast[c][fwp[c]] = last_at_end && (k == n - 1);
      pseq[c]++;
      fwp[c] = fwp[c] + 1'b1;
    end
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    for (int i = 0; i < 3000 && quiet < 12; i++) begin
      step(1);
      if (outs == 0 && !aw_valid && !w_valid) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic t_reset();
    check(!aw_valid && !w_valid, "R1", "valids low after reset", {aw_valid, w_valid}, 0);
    check(st_wr_issued == '0 && st_fs_issued == '0, "R1", "issued pointers zero",
          st_wr_issued == '0, 1);
    check(st_wr_done == '0 && st_fs_done == '0, "R1", "confirmed pointers zero",
          st_wr_done == '0, 1);
    check(!st_err, "R1", "error flag clear", st_err, 0);
  endtask

  task automatic t_below_threshold();
    push(0, 10, 1'b0);
    step(40);
    check(nburst == 0, "R2", "no burst below 16 words", nburst, 0);
    check(int'(ch_level[0 +: LVW]) == 10, "R2", "ch0 FIFO untouched", ch_level[0 +: LVW], 10);
  endtask

  task automatic t_full_burst();
    int n0;
    n0 = nburst;
    push(0, 6, 1'b0);
    wait_idle();
    check(nburst == n0 + 1 && log_tag[n0] == 0, "R3", "one burst for ch0", nburst - n0, 1);
    check(log_len[n0] == 16, "R3", "full burst length", log_len[n0], 16);
    check(fld(st_wr_issued, 0) == 16, "R8", "ch0 issued pointer", fld(st_wr_issued, 0), 16);
    check(fld(st_wr_done, 0) == 16, "R9", "ch0 confirmed pointer", fld(st_wr_done, 0), 16);
  endtask

  task automatic t_flush_short();
    int n0;
    n0 = nburst;
    push(1, 5, 1'b1);
    ch_flush[1] = 1'b1;
    wait_idle();
    ch_flush[1] = 1'b0;
    check(nburst == n0 + 1 && log_len[n0] == 5, "R4", "short burst on flush", log_len[n0], 5);
    check(fld(st_wr_issued, 1) == 5, "R8", "ch1 issued pointer", fld(st_wr_issued, 1), 5);
    check(fld(st_fs_issued, 1) == 5, "R8", "ch1 issued frame start", fld(st_fs_issued, 1), 5);
    check(fld(st_fs_done, 1) == 5, "R9", "ch1 confirmed frame start", fld(st_fs_done, 1), 5);
  endtask

  task automatic t_wrap();
    int n0;
    n0 = nburst;
    push(2, 16, 1'b0);
    wait_idle();
    push(2, 8, 1'b1);
    ch_flush[2] = 1'b1;
    wait_idle();
    ch_flush[2] = 1'b0;
    check(nburst == n0 + 3, "R5", "ch2 bursts around wrap", nburst - n0, 3);
    check(log_len[n0+1] == 4 && log_len[n0+2] == 4, "R5", "split at buffer end",
          log_len[n0+1] * 100 + log_len[n0+2], 404);
    check(fld(st_wr_issued, 2) == 4, "R5", "ch2 offset wrapped", fld(st_wr_issued, 2), 4);
    check(fld(st_fs_issued, 2) == 4, "R8", "ch2 frame start after wrap", fld(st_fs_issued, 2), 4);
  endtask

  task automatic t_round_robin();
    int n0;
    n0 = nburst;
    stall = 1'b1;
    for (int c = 0; c < NCH; c++) push(c, 16, 1'b0);
    wait_idle();
    stall = 1'b0;
    check(nburst == n0 + 4, "R7", "one burst per channel", nburst - n0, 4);
    check(log_tag[n0] == 3 && log_tag[n0+1] == 0 && log_tag[n0+2] == 1 && log_tag[n0+3] == 2,
          "R7", "grant order after ch2",
          log_tag[n0]*1000 + log_tag[n0+1]*100 + log_tag[n0+2]*10 + log_tag[n0+3], 3012);
  endtask

  task automatic t_outstanding();
    int n0;
    n0 = nburst;
    b_hold = 1'b1;
    for (int c = 0; c < NCH; c++) push(c, 16, 1'b0);
    push(0, 16, 1'b0);
    step(200);
    check(nburst == n0 + 4, "R10", "bursts while responses held", nburst - n0, 4);
    check(outs_max == 4, "R10", "peak outstanding", outs_max, 4);
    check(fld(st_wr_issued, 1) == 37, "R8", "ch1 issued ahead", fld(st_wr_issued, 1), 37);
    check(fld(st_wr_done, 1) == 21, "R9", "ch1 confirmed held", fld(st_wr_done, 1), 21);
    b_hold = 1'b0;
    wait_idle();
    check(nburst == n0 + 5, "R10", "fifth burst after release", nburst - n0, 5);
    check(fld(st_wr_done, 1) == 37 && fld(st_wr_done, 0) == 0, "R9",
          "confirmed caught up", fld(st_wr_done, 1), 37);
  endtask

  task automatic t_error();
    resp_code = 2'b10;
    push(3, 16, 1'b0);
    wait_idle();
    check(st_err, "R11", "error after non-OKAY", st_err, 1);
    resp_code = 2'b00;
    push(3, 16, 1'b0);
    wait_idle();
    check(st_err, "R11", "error stays set", st_err, 1);
    check(fld(st_wr_done, 3) == 16, "R9", "ch3 confirmed despite error", fld(st_wr_done, 3), 16);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    b_hold = 0; stall = 0; resp_code = 2'b00;
    bbase[0] = 'h1000; bsize[0] = 64;
    bbase[1] = 'h2000; bsize[1] = 64;
    bbase[2] = 'h3000; bsize[2] = 20;
    bbase[3] = 'h4000; bsize[3] = 48;
    for (int c = 0; c < NCH; c++) begin
      cfg_base[c*PW +: PW] = PW'(bbase[c]);
      cfg_size[c*PW +: PW] = PW'(bsize[c]);
      fwp[c] = '0; pseq[c] = 0;
      for (int k = 0; k < 64; k++) begin
        fdat[c][k] = '0; flast[c][k] = 1'b0;
      end
    end
    ch_flush = '0;
    rst_n = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(6);
    t_reset();
    t_below_threshold();
    t_full_burst();
    t_flush_short();
    t_wrap();
    t_round_robin();
    t_outstanding();
    t_error();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad);
      $finish;
    end
  end
endmodule